// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block turns a transfer descriptor into the stream of internal memory addresses that a DMA channel walks through. A descriptor holds a 32-bit start address, an element count and a signed byte stride for the inner (X) dimension, and a row count and a signed byte stride for the outer (Y) dimension, plus a mode bit that picks one-dimensional or two-dimensional walking and a flow bit that picks stop or auto-buffer behaviour. Counts are in bus words; strides are in bytes, so consecutive 32-bit words use a stride of 4.

Once a descriptor is loaded, the block presents one address at a time with `addr_valid` high. The consumer accepts it by raising `addr_ack` for one clock cycle, and the block moves to the next address. In stop flow the walk ends after the last element with a one-cycle `done` pulse. In auto-buffer flow it returns to the start address and repeats without end. A `finish` input aborts the walk at once. A descriptor with a zero element count, or a two-dimensional descriptor with a zero row count, is refused and raises `error`.

Top module: `dagen_top`

## Requirements
- R1: After reset, `addr_valid`, `done` and `error` are all 0.
- R2: In the cycle after `desc_valid` is sampled high with a usable descriptor, `addr_valid` is 1 and `addr` equals the loaded start address.
- R3: In one-dimensional mode (`desc_2d`=0), each accepted handshake adds the sign-extended X stride to `addr`, exactly X count addresses are produced, and the Y count and Y stride values have no effect.
- R4: While `addr_valid` is 1 and `addr_ack` is 0, `addr` holds its value.
- R5: In two-dimensional mode (`desc_2d`=1), after the last element of a row is accepted the next address is that element's address plus the sign-extended Y stride; the walk covers Y count rows of X count elements.
- R6: Strides are 16-bit two's complement values, so a stride with bit 15 set moves the address downward.
- R7: In stop flow (`desc_autobuf`=0), after the final element is accepted `addr_valid` goes to 0 and `done` is 1 for exactly one cycle, the cycle after the accepting edge.
- R8: In auto-buffer flow (`desc_autobuf`=1), after the final element is accepted the next address is the start address again, the counts restart, `addr_valid` stays 1 and `done` stays 0.
- R9: A descriptor with X count 0, or with `desc_2d`=1 and Y count 0, sets `error` to 1 and leaves `addr_valid` at 0; `error` returns to 0 on the next usable descriptor load.
- R10: `finish` sampled high drops `addr_valid` on the next cycle without a `done` pulse; it takes priority over `addr_ack` and over `desc_valid` in the same cycle.
- R11: A usable descriptor loaded while a walk is active replaces it at once, taking priority over an `addr_ack` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor load strobe, one cycle |
| desc_start | input | 32 | Start byte address |
| desc_xcnt | input | 16 | Elements per row (bus words) |
| desc_xmod | input | 16 | Signed byte stride between elements |
| desc_ycnt | input | 16 | Row count (2-D mode) |
| desc_ymod | input | 16 | Signed byte stride from a row's last element to the next row's first |
| desc_2d | input | 1 | 1 selects two-dimensional walking |
| desc_autobuf | input | 1 | 1 selects auto-buffer flow, 0 stop flow |
| finish | input | 1 | Abort the active walk |
| addr_ack | input | 1 | Current address accepted this cycle |
| addr_valid | output | 1 | An address is being presented |
| addr | output | 32 | Current byte address |
| done | output | 1 | One-cycle pulse after the last element in stop flow |
| error | output | 1 | Last descriptor was refused |

## Verification
The address walk is driven with a table of descriptors: a 1-D walk with non-zero Y fields, which shows whether the Y values leak into a 1-D walk; a 1-D walk with a negative stride, which separates sign extension from zero extension; 2-D walks with positive and negative row strides, which show that the row step uses the Y stride rather than the X stride and counts rows correctly; and a single-element 2-D walk, where the first address is also the last. A stall inside each walk shows whether the address holds without a handshake. Directed cases then cover the auto-buffer wrap, refused descriptors and error clearing, abort priority, and a reload during an active walk.

// File: rtl/dagen_pkg.sv
package dagen_pkg;

  // Kind of address update requested by the walk controller.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_X    = 2'd1,
    STEP_Y    = 2'd2,
    STEP_WRAP = 2'd3
  } step_e;

endpackage

// File: rtl/dagen_desc_store.sv
module dagen_desc_store #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [AW-1:0] in_start,
  input  logic [CW-1:0] in_xcnt,
  input  logic [MW-1:0] in_xmod,
  input  logic [CW-1:0] in_ycnt,
  input  logic [MW-1:0] in_ymod,
  input  logic          in_2d,
  input  logic          in_autobuf,
  output logic [AW-1:0] h_start,
  output logic [CW-1:0] h_xcnt,
  output logic [MW-1:0] h_xmod,
  output logic [CW-1:0] h_ycnt,
  output logic [MW-1:0] h_ymod,
  output logic          h_2d,
  output logic          h_autobuf
);

  // Held copy of the accepted descriptor, used for row reloads and wraps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_start   <= '0;
      h_xcnt    <= '0;
      h_xmod    <= '0;
      h_ycnt    <= '0;
      h_ymod    <= '0;
      h_2d      <= 1'b0;
      h_autobuf <= 1'b0;
    end else if (cap) begin
      h_start   <= in_start;
      h_xcnt    <= in_xcnt;
      h_xmod    <= in_xmod;
      h_ycnt    <= in_ycnt;
      h_ymod    <= in_ymod;
      h_2d      <= in_2d;
      h_autobuf <= in_autobuf;
    end
  end

endmodule

// File: rtl/dagen_walk.sv
module dagen_walk
  import dagen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_valid,
  input  logic          finish,
  input  logic          addr_ack,
  input  logic [CW-1:0] in_xcnt,
  input  logic [CW-1:0] in_ycnt,
  input  logic          in_2d,
  input  logic [CW-1:0] h_xcnt,
  input  logic [CW-1:0] h_ycnt,
  input  logic          h_2d,
  input  logic          h_autobuf,
  output logic          load_ok,
  output step_e         step,
  output logic          active,
  output logic          done,
  output logic          error
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] xrem_q, xrem_d;
  logic [CW-1:0] yrem_q, yrem_d;
  logic          active_q, active_d;
  logic          done_q, done_d;
  logic          error_q, error_d;
  logic          load_bad, take, row_end, last_elem;

  // Next-state logic.
  always_comb begin
    load_ok   = desc_valid && !finish && (in_xcnt != '0) && !(in_2d && (in_ycnt == '0));
    load_bad  = desc_valid && !finish && !load_ok;
    take      = active_q && addr_ack && !finish && !desc_valid;
    row_end   = (xrem_q == ONE);
    last_elem = row_end && (yrem_q == ONE);

    xrem_d   = xrem_q;
    yrem_d   = yrem_q;
    active_d = active_q;
    error_d  = error_q;
    done_d   = 1'b0;
    step     = STEP_HOLD;

    if (finish) begin
      active_d = 1'b0;
    end else if (load_ok) begin
      active_d = 1'b1;
      error_d  = 1'b0;
      xrem_d   = in_xcnt;
      yrem_d   = in_2d ? in_ycnt : ONE;
    end else if (load_bad) begin
      active_d = 1'b0;
      error_d  = 1'b1;
    end else if (take) begin
      if (!row_end) begin
        step   = STEP_X;
        xrem_d = xrem_q - ONE;
      end else if (!last_elem) begin
        step   = STEP_Y;
        xrem_d = h_xcnt;
        yrem_d = yrem_q - ONE;
      end else if (h_autobuf) begin
        step   = STEP_WRAP;
        xrem_d = h_xcnt;
        yrem_d = h_2d ? h_ycnt : ONE;
      end else begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xrem_q   <= '0;
      yrem_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      error_q  <= 1'b0;
    end else begin
      xrem_q   <= xrem_d;
      yrem_q   <= yrem_d;
      active_q <= active_d;
      done_q   <= done_d;
      error_q  <= error_d;
    end
  end

  assign active = active_q;
  assign done   = done_q;
  assign error  = error_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> !active_q); // R7
  AST_ERROR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) error_q |-> !active_q); // R9
  AST_FINISH_HALT: assert property (@(posedge clk) disable iff (!rst_n) finish |=> (!active_q && !done_q)); // R10
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n) active_q |-> (xrem_q != '0 && yrem_q != '0)); // R3

endmodule

// File: rtl/dagen_addr_acc.sv
module dagen_addr_acc
  import dagen_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_start,
  input  logic [AW-1:0] h_start,
  input  logic [MW-1:0] h_xmod,
  input  logic [MW-1:0] h_ymod,
  input  step_e         step,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] xinc, yinc;
  logic [AW-1:0] addr_q, addr_d;

  // Sign-extend or truncate strides to the address width.
  generate
    if (MW < AW) begin : g_sext
      assign xinc = {{(AW-MW){h_xmod[MW-1]}}, h_xmod};
      assign yinc = {{(AW-MW){h_ymod[MW-1]}}, h_ymod};
    end else begin : g_trunc
      assign xinc = h_xmod[AW-1:0];
      assign yinc = h_ymod[AW-1:0];
    end
  endgenerate

  always_comb begin
    addr_d = addr_q;
    if (load) begin
      addr_d = in_start;
    end else begin
      case (step)
        STEP_X:    addr_d = addr_q + xinc;
        STEP_Y:    addr_d = addr_q + yinc;
        STEP_WRAP: addr_d = h_start;
        default:   addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!load && step == STEP_HOLD) |=> $stable(addr_q)); // R4

endmodule

// File: rtl/dagen_top.sv
module dagen_top
  import dagen_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_valid,
  input  logic [AW-1:0] desc_start,
  input  logic [CW-1:0] desc_xcnt,
  input  logic [MW-1:0] desc_xmod,
  input  logic [CW-1:0] desc_ycnt,
  input  logic [MW-1:0] desc_ymod,
  input  logic          desc_2d,
  input  logic          desc_autobuf,
  input  logic          finish,
  input  logic          addr_ack,
  output logic          addr_valid,
  output logic [AW-1:0] addr,
  output logic          done,
  output logic          error
);

  logic          load_ok;
  step_e         step;
  logic [AW-1:0] h_start;
  logic [CW-1:0] h_xcnt, h_ycnt;
  logic [MW-1:0] h_xmod, h_ymod;
  logic          h_2d, h_autobuf;

  dagen_desc_store #(.AW(AW), .CW(CW), .MW(MW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (load_ok),
    .in_start   (desc_start),
    .in_xcnt    (desc_xcnt),
    .in_xmod    (desc_xmod),
    .in_ycnt    (desc_ycnt),
    .in_ymod    (desc_ymod),
    .in_2d      (desc_2d),
    .in_autobuf (desc_autobuf),
    .h_start    (h_start),
    .h_xcnt     (h_xcnt),
    .h_xmod     (h_xmod),
    .h_ycnt     (h_ycnt),
    .h_ymod     (h_ymod),
    .h_2d       (h_2d),
    .h_autobuf  (h_autobuf)
  );

  dagen_walk #(.CW(CW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .finish     (finish),
    .addr_ack   (addr_ack),
    .in_xcnt    (desc_xcnt),
    .in_ycnt    (desc_ycnt),
    .in_2d      (desc_2d),
    .h_xcnt     (h_xcnt),
    .h_ycnt     (h_ycnt),
    .h_2d       (h_2d),
    .h_autobuf  (h_autobuf),
    .load_ok    (load_ok),
    .step       (step),
    .active     (addr_valid),
    .done       (done),
    .error      (error)
  );

  dagen_addr_acc #(.AW(AW), .MW(MW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ok),
    .in_start (desc_start),
    .h_start  (h_start),
    .h_xmod   (h_xmod),
    .h_ymod   (h_ymod),
    .step     (step),
    .addr     (addr)
  );

  AST_START_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !finish && desc_xcnt != '0 && !desc_2d) |=> (addr_valid && addr == $past(desc_start))); // R2
  AST_ACK_MOVES_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !desc_valid) |=> !addr_valid); // R9

endmodule

// File: tb/dagen_top_test.sv
`timescale 1ns/1ps
module dagen_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        desc_valid, desc_2d, desc_autobuf, finish, addr_ack;
  logic [31:0] desc_start;
  logic [15:0] desc_xcnt, desc_xmod, desc_ycnt, desc_ymod;
  logic        addr_valid, done, error;
  logic [31:0] addr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dagen_top uut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_start(desc_start),
    .desc_xcnt(desc_xcnt), .desc_xmod(desc_xmod), .desc_ycnt(desc_ycnt),
    .desc_ymod(desc_ymod), .desc_2d(desc_2d), .desc_autobuf(desc_autobuf),
    .finish(finish), .addr_ack(addr_ack), .addr_valid(addr_valid), .addr(addr),
    .done(done), .error(error)
  );

  typedef struct packed {
    logic [31:0] st;
    logic [15:0] xc;
    logic [15:0] xm;
    logic [15:0] yc;
    logic [15:0] ym;
    logic        two;
  } vec_t;

  localparam vec_t [0:4] VECS = '{
    '{st: 32'h0000_1000, xc: 16'd4, xm: 16'h0004, yc: 16'd7, ym: 16'h0055, two: 1'b0},
    '{st: 32'h0000_2000, xc: 16'd3, xm: 16'hFFFC, yc: 16'd0, ym: 16'h0000, two: 1'b0},
    '{st: 32'h0000_0100, xc: 16'd3, xm: 16'h0002, yc: 16'd2, ym: 16'h000A, two: 1'b1},
    '{st: 32'h0000_8000, xc: 16'd2, xm: 16'h0004, yc: 16'd3, ym: 16'hFFF4, two: 1'b1},
    '{st: 32'h0000_0040, xc: 16'd1, xm: 16'h0004, yc: 16'd1, ym: 16'h0010, two: 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] st, input logic [15:0] xc,
                                           input logic [15:0] xm, input logic [15:0] ym,
                                           input int r, input int c);
    int xmi;
    int ymi;
    xmi = int'($signed(xm));
    ymi = int'($signed(ym));
    return st + 32'(r * ((int'(xc) - 1) * xmi + ymi) + c * xmi);
  endfunction

  // Drive a descriptor for one cycle; returns at the following falling edge.
  task automatic load(input logic [31:0] st, input logic [15:0] xc, input logic [15:0] xm,
                      input logic [15:0] yc, input logic [15:0] ym, input logic two, input logic ab);
    desc_valid = 1'b1; desc_start = st; desc_xcnt = xc; desc_xmod = xm;
    desc_ycnt = yc; desc_ymod = ym; desc_2d = two; desc_autobuf = ab;
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic accept;
    addr_ack = 1'b1;
    @(negedge clk);
    addr_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; desc_valid = 1'b0; desc_start = '0; desc_xcnt = '0; desc_xmod = '0;
    desc_ycnt = '0; desc_ymod = '0; desc_2d = 1'b0; desc_autobuf = 1'b0;
    finish = 1'b0; addr_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!addr_valid, "R1 valid", 32'(addr_valid), 0);
    chk(!done, "R1 done", 32'(done), 0);
    chk(!error, "R1 error", 32'(error), 0);

    // Table walk: R2, R3, R4, R5, R6, R7
    for (int v = 0; v < 5; v++) begin
      vec_t t;
      string tag;
      int rows;
      t = VECS[v];
      tag = t.two ? "R5" : "R3";
      if (t.xm[15] || (t.two && t.ym[15])) tag = {tag, "/R6"};
      rows = t.two ? int'(t.yc) : 1;
      load(t.st, t.xc, t.xm, t.yc, t.ym, t.two, 1'b0);
      chk(addr_valid && addr == t.st, "R2 start", addr, t.st);
      for (int r = 0; r < rows; r++) begin
        for (int c = 0; c < int'(t.xc); c++) begin
          logic [31:0] e;
          e = exp_addr(t.st, t.xc, t.xm, t.ym, r, c);
          chk(addr_valid && addr == e, tag, addr, e);
          if (r == 0 && c == 1) begin
            @(negedge clk);
            chk(addr == e, "R4 hold", addr, e);
          end
          accept();
        end
      end
      chk(done && !addr_valid, "R7 done", {30'd0, done, addr_valid}, 32'h2);
      @(negedge clk);
      chk(!done, "R7 pulse", 32'(done), 0);
    end

    // R8 auto-buffer wrap
    load(32'h4000, 16'd2, 16'h0008, 16'd2, 16'h0020, 1'b1, 1'b1);
    addr_ack = 1'b1;
    for (int i = 0; i < 7; i++) begin
      logic [31:0] e;
      case (i % 4)
        0: e = 32'h4000;
        1: e = 32'h4008;
        2: e = 32'h4028;
        default: e = 32'h4030;
      endcase
      chk(addr_valid && !done && addr == e, "R8 wrap", addr, e);
      @(negedge clk);
    end
    // R10 abort beats ack
    finish = 1'b1;
    @(negedge clk);
    finish = 1'b0; addr_ack = 1'b0;
    chk(!addr_valid && !done, "R10 abort", {30'd0, addr_valid, done}, 0);
    @(negedge clk);
    chk(!done && !addr_valid, "R10 no done", {30'd0, addr_valid, done}, 0);

    // R9 refused descriptors
    load(32'h500, 16'd0, 16'h4, 16'd0, 16'h0, 1'b0, 1'b0);
    chk(error && !addr_valid, "R9 xcnt0", {30'd0, error, addr_valid}, 32'h2);
    accept();
    chk(!addr_valid, "R9 ack ignored", 32'(addr_valid), 0);
    load(32'h500, 16'd2, 16'h4, 16'd0, 16'h0, 1'b1, 1'b0);
    chk(error && !addr_valid, "R9 ycnt0", {30'd0, error, addr_valid}, 32'h2);
    load(32'h600, 16'd1, 16'h4, 16'd0, 16'h0, 1'b0, 1'b0);
    chk(!error && addr_valid && addr == 32'h600, "R9 cleared", addr, 32'h600);
    accept();
    chk(done, "R7 single", 32'(done), 1);
    @(negedge clk);

    // R11 reload during active walk, beating ack
    load(32'h100, 16'd4, 16'h4, 16'd0, 16'h0, 1'b0, 1'b0);
    accept();
    chk(addr == 32'h104, "R11 first", addr, 32'h104);
    addr_ack = 1'b1;
    load(32'h900, 16'd2, 16'h1, 16'd0, 16'h0, 1'b0, 1'b0);
    addr_ack = 1'b0;
    chk(addr_valid && addr == 32'h900, "R11 reload", addr, 32'h900);
    accept();
    chk(addr == 32'h901, "R11 step", addr, 32'h901);
    accept();
    chk(done, "R11 done", 32'(done), 1);
    @(negedge clk);

    // R10 abort beats load
    finish = 1'b1;
    load(32'hA00, 16'd2, 16'h4, 16'd0, 16'h0, 1'b0, 1'b0);
    finish = 1'b0;
    chk(!addr_valid && !error, "R10 over load", {30'd0, addr_valid, error}, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule